// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a register port and a byte-level I2C bit engine. Software loads a byte buffer and then writes a command word. The command word may request any mix of five phases: address start, byte transmit, byte receive, final byte receive and stop. The sequencer runs the requested phases over a request/done handshake to the bit engine. Each phase waits until the engine reports that it has finished.

While it works, the sequencer keeps a 4-bit transfer-state field in the command register. The active flag of that field decides two things. A start issued while a transfer is already open is marked as a repeated start. A stop issued outside an open transfer is reported as abnormal, and nothing is driven on the bus. Four sticky interrupt flags report the outcome: acknowledged byte, not-acknowledged, normal stop and abnormal stop. A new command clears all four.

Top module: `i2c_cmd_seq`

## Requirements
- R1: An accepted command write clears all four interrupt flags before any phase runs. A command write that arrives while a sequence is still running is ignored.
- R2: When a command word has several bits set, the phases run in the fixed order start, transmit, receive, stop. The command bits are: bit0 start, bit1 transmit, bit2 receive, bit3 receive-last and bit4 stop. Each bit clears when its phase finishes.
- R3: The state field is IDLE=0x0 or one of the active values, which all have bit 3 set: ACTIVE=0x8, START=0x9, RESTART=0xA, TXD=0xB, RXD=0xC and STOPPING=0xD. A start phase sets RESTART when the current state has bit 3 set, and START otherwise.
- R4: A start phase sends buffer bits [7:0] as the address byte: address in [7:1], direction in [0]. A missing acknowledge sets the NAK flag. If the bus is not busy when the start completes, every remaining command bit is dropped and the state keeps its start value. Otherwise the state becomes ACTIVE.
- R5: During a transmit phase the state is TXD. An acknowledge sets the ACK flag. A not-acknowledge sets only the NAK flag, never the abnormal flag, and the block then issues a bus stop operation. In both cases the state then returns to ACTIVE.
- R6: During a receive phase the state is RXD. The received byte goes to buffer bits [15:8], or 0xFF when the engine reports a failed read. The receive-last variant requests a NACK answer. The state then returns to ACTIVE.
- R7: A stop phase in a state without bit 3 sets the abnormal flag and issues no bus operation. A stop phase in an active state shows STOPPING, issues a bus stop and sets the normal-stop flag. After any stop phase the state is IDLE.
- R8: The register map is: address 0 holds the command bits in [4:0] and the state field in [22:19]; address 1 holds the 16-bit buffer; address 2 holds the flags (bit0 ACK, bit1 NAK, bit2 normal stop, bit3 abnormal). Reads are registered, and every register resets to zero.
- R9: A bus request stays high with a stable operation code until the engine answers done. The operation codes are 0 start, 1 send, 2 receive and 3 stop. No request is made while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data |
| bus_req | output | 1 | Phase request to the bit engine |
| bus_op | output | 2 | Requested operation code |
| bus_wdata | output | 8 | Byte to send (address or data) |
| bus_nack_last | output | 1 | Answer the received byte with NACK |
| bus_done | input | 1 | Engine finished the requested phase |
| bus_ack | input | 1 | Acknowledge seen for start or send |
| bus_busy | input | 1 | Bus held by this master, valid with done |
| bus_rd_ok | input | 1 | Receive produced a valid byte |
| bus_rdata | input | 8 | Received byte |
| irq_status | output | 4 | Sticky interrupt flags |

## Verification
The bench targets these corner cases:
- A start after an open transfer. A design that ignores the active flag would report a plain start where a repeated start is expected.
- A start that finds no device. A design that continued anyway would issue transmit or stop phases on an idle bus.
- A transmit NAK. A wrong design would set the abnormal flag as well, or would fail to release the bus.
- A stop outside a transfer. A wrong design would drive a stop on the bus and report it as normal.
- A failed read, a final-byte receive and a command write during a run. A wrong design would return stale data, answer with the wrong ACK or NACK, or let the second command corrupt the first.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 16;
  localparam int ST_W    = 4;
  localparam int ST_LSB  = 19;
  localparam int IRQ_W   = 4;

  // command bit positions
  localparam int C_START = 0;
  localparam int C_TX    = 1;
  localparam int C_RX    = 2;
  localparam int C_RXL   = 3;
  localparam int C_STOP  = 4;

  // interrupt flag positions
  localparam int I_ACK   = 0;
  localparam int I_NAK   = 1;
  localparam int I_NSTOP = 2;
  localparam int I_ABN   = 3;

  // transfer-state codes; bit 3 marks an open transfer
  localparam logic [ST_W-1:0] ST_IDLE    = 4'h0;
  localparam logic [ST_W-1:0] ST_ACTIVE  = 4'h8;
  localparam logic [ST_W-1:0] ST_START   = 4'h9;
  localparam logic [ST_W-1:0] ST_RESTART = 4'hA;
  localparam logic [ST_W-1:0] ST_TXD     = 4'hB;
  localparam logic [ST_W-1:0] ST_RXD     = 4'hC;
  localparam logic [ST_W-1:0] ST_STOPPING = 4'hD;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_t;

  typedef enum logic [2:0] {
    F_IDLE, F_DISP, F_START, F_TX, F_TXEND, F_RX, F_STOP
  } seq_fsm_t;
endpackage

// File: rtl/i2c_seq_irq.sv
module i2c_seq_irq
  import i2c_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [IRQ_W-1:0] set,
  output logic [IRQ_W-1:0] irq
);
  always_ff @(posedge clk) begin
    if (rst)      irq <= '0;
    else if (clr) irq <= '0;
    else          irq <= irq | set;
  end

  AST_CLR_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    clr |=> (irq == '0));  // R1
  AST_NAK_NOT_ABN: assert property (@(posedge clk) disable iff (rst)
    !(irq[I_NAK] && irq[I_ABN]));  // R5
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              buf_wr,
  input  logic [2*BYTE_W-1:0] buf_wdata,
  output logic              cmd_take,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [ST_W-1:0]   xfer_st,
  output logic [2*BYTE_W-1:0] buf_q,
  output logic [IRQ_W-1:0]  set_q,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_nack_last,
  input  logic              bus_done,
  input  logic              bus_ack,
  input  logic              bus_busy,
  input  logic              bus_rd_ok,
  input  logic [BYTE_W-1:0] bus_rdata
);
  seq_fsm_t fsm;

  assign cmd_take = cmd_wr && (fsm == F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm           <= F_IDLE;
      cmd_q         <= '0;
      xfer_st       <= ST_IDLE;
      buf_q         <= '0;
      set_q         <= '0;
      bus_req       <= 1'b0;
      bus_op        <= OP_START;
      bus_wdata     <= '0;
      bus_nack_last <= 1'b0;
    end else begin
      set_q <= '0;
      case (fsm)
        F_IDLE: begin
          if (cmd_wr) begin
            cmd_q <= cmd_wdata;
            fsm   <= F_DISP;
          end else if (buf_wr) begin
            buf_q <= buf_wdata;
          end
        end
        F_DISP: begin
          if (cmd_q[C_START]) begin
            xfer_st   <= xfer_st[3] ? ST_RESTART : ST_START;
            bus_req   <= 1'b1;
            bus_op    <= OP_START;
            bus_wdata <= buf_q[BYTE_W-1:0];
            fsm       <= F_START;
          end else if (cmd_q[C_TX]) begin
            xfer_st   <= ST_TXD;
            bus_req   <= 1'b1;
            bus_op    <= OP_SEND;
            bus_wdata <= buf_q[BYTE_W-1:0];
            fsm       <= F_TX;
          end else if (cmd_q[C_RX] || cmd_q[C_RXL]) begin
            xfer_st       <= ST_RXD;
            bus_req       <= 1'b1;
            bus_op        <= OP_RECV;
            bus_nack_last <= cmd_q[C_RXL];
            fsm           <= F_RX;
          end else if (cmd_q[C_STOP]) begin
            if (xfer_st[3]) begin
              xfer_st <= ST_STOPPING;
              bus_req <= 1'b1;
              bus_op  <= OP_STOP;
              fsm     <= F_STOP;
            end else begin
              set_q[I_ABN]   <= 1'b1;
              cmd_q[C_STOP]  <= 1'b0;
              xfer_st        <= ST_IDLE;
            end
          end else begin
            fsm <= F_IDLE;
          end
        end
        F_START: if (bus_done) begin
          bus_req        <= 1'b0;
          set_q[I_NAK]   <= !bus_ack;
          cmd_q[C_START] <= 1'b0;
          if (!bus_busy) cmd_q   <= '0;
          else           xfer_st <= ST_ACTIVE;
          fsm <= F_DISP;
        end
        F_TX: if (bus_done) begin
          if (bus_ack) begin
            bus_req     <= 1'b0;
            set_q[I_ACK] <= 1'b1;
            xfer_st     <= ST_ACTIVE;
            cmd_q[C_TX] <= 1'b0;
            fsm         <= F_DISP;
          end else begin
            set_q[I_NAK] <= 1'b1;
            bus_op       <= OP_STOP;
            fsm          <= F_TXEND;
          end
        end
        F_TXEND: if (bus_done) begin
          bus_req     <= 1'b0;
          xfer_st     <= ST_ACTIVE;
          cmd_q[C_TX] <= 1'b0;
          fsm         <= F_DISP;
        end
        F_RX: if (bus_done) begin
          bus_req <= 1'b0;
          buf_q[2*BYTE_W-1:BYTE_W] <= bus_rd_ok ? bus_rdata : {BYTE_W{1'b1}};
          cmd_q[C_RX]  <= 1'b0;
          cmd_q[C_RXL] <= 1'b0;
          xfer_st <= ST_ACTIVE;
          fsm     <= F_DISP;
        end
        F_STOP: if (bus_done) begin
          bus_req        <= 1'b0;
          set_q[I_NSTOP] <= 1'b1;
          cmd_q[C_STOP]  <= 1'b0;
          xfer_st        <= ST_IDLE;
          fsm            <= F_DISP;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_op)));  // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (fsm == F_IDLE) |-> !bus_req);  // R9
  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
    (xfer_st == ST_IDLE) || xfer_st[3]);  // R3
  AST_ABN_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    set_q[I_ABN] |-> (!bus_req && xfer_st == ST_IDLE));  // R7
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              bus_nack_last,
  input  logic              bus_done,
  input  logic              bus_ack,
  input  logic              bus_busy,
  input  logic              bus_rd_ok,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic [IRQ_W-1:0]  irq_status
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(2);

  logic                cmd_take;
  logic [CMD_W-1:0]    cmd_q;
  logic [ST_W-1:0]     xfer_st;
  logic [2*BYTE_W-1:0] buf_q;
  logic [IRQ_W-1:0]    set_q;
  logic                unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:CMD_W];

  i2c_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cmd_wr        (reg_wr_en && reg_addr == A_CMD),
    .cmd_wdata     (reg_wdata[CMD_W-1:0]),
    .buf_wr        (reg_wr_en && reg_addr == A_BUF),
    .buf_wdata     (reg_wdata[2*BYTE_W-1:0]),
    .cmd_take      (cmd_take),
    .cmd_q         (cmd_q),
    .xfer_st       (xfer_st),
    .buf_q         (buf_q),
    .set_q         (set_q),
    .bus_req       (bus_req),
    .bus_op        (bus_op),
    .bus_wdata     (bus_wdata),
    .bus_nack_last (bus_nack_last),
    .bus_done      (bus_done),
    .bus_ack       (bus_ack),
    .bus_busy      (bus_busy),
    .bus_rd_ok     (bus_rd_ok),
    .bus_rdata     (bus_rdata)
  );

  i2c_seq_irq u_irq (
    .clk (clk),
    .rst (rst),
    .clr (cmd_take),
    .set (set_q),
    .irq (irq_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        A_CMD: begin
          reg_rdata[CMD_W-1:0]          <= cmd_q;
          reg_rdata[ST_LSB+ST_W-1:ST_LSB] <= xfer_st;
        end
        A_BUF: reg_rdata[2*BYTE_W-1:0] <= buf_q;
        A_IRQ: reg_rdata[IRQ_W-1:0]    <= irq_status;
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (irq_status == '0 && !bus_req));  // R8
endmodule

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int NV = 9;

  typedef struct packed {
    logic [4:0] cmd;
    logic [7:0] bfr;
    logic       sack, tack, rok;
    logic [7:0] rdat;
    logic [3:0] irq;
    logic [3:0] st;
    logic       chk_rx;
    logic [7:0] rx;
    logic [3:0] n;
    logic [7:0] seq;
    logic [3:0] st0;
    logic       nack;
  } vec_t;

  // cmd bits: 1 start, 2 tx, 4 rx, 8 rx-last, 16 stop; ops 0 start 1 send 2 recv 3 stop
  localparam vec_t VECS [NV] = '{
    '{5'h10, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 4'h8, 4'h0, 1'b0, 8'h00, 4'd0, 8'h00, 4'h0, 1'b0},
    '{5'h03, 8'hA0, 1'b1, 1'b1, 1'b1, 8'h00, 4'h1, 4'h8, 1'b0, 8'h00, 4'd2, 8'h04, 4'h9, 1'b0},
    '{5'h19, 8'hA1, 1'b1, 1'b1, 1'b1, 8'h5A, 4'h4, 4'h0, 1'b1, 8'h5A, 4'd3, 8'h38, 4'hA, 1'b1},
    '{5'h03, 8'hA0, 1'b1, 1'b0, 1'b1, 8'h00, 4'h2, 4'h8, 1'b0, 8'h00, 4'd3, 8'h34, 4'h9, 1'b0},
    '{5'h10, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 4'h4, 4'h0, 1'b0, 8'h00, 4'd1, 8'h03, 4'hD, 1'b0},
    '{5'h13, 8'h42, 1'b0, 1'b1, 1'b1, 8'h00, 4'h2, 4'h9, 1'b0, 8'h00, 4'd1, 8'h00, 4'h9, 1'b0},
    '{5'h10, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 4'h4, 4'h0, 1'b0, 8'h00, 4'd1, 8'h03, 4'hD, 1'b0},
    '{5'h05, 8'h31, 1'b1, 1'b1, 1'b0, 8'h77, 4'h0, 4'h8, 1'b1, 8'hFF, 4'd2, 8'h08, 4'h9, 1'b0},
    '{5'h17, 8'h30, 1'b1, 1'b1, 1'b1, 8'h3C, 4'h5, 4'h0, 1'b1, 8'h3C, 4'd4, 8'hE4, 4'hA, 1'b0}
  };

  logic        clk = 0, rst = 1;
  logic        reg_wr_en = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        bus_req, bus_nack_last;
  logic [1:0]  bus_op;
  logic [7:0]  bus_wdata;
  logic        bus_done = 0, bus_ack = 0, bus_busy = 0, bus_rd_ok = 0;
  logic [7:0]  bus_rdata = 0;
  logic [3:0]  irq_status;

  logic m_sack = 1, m_tack = 1, m_rok = 1;
  logic [7:0] m_rdata = 0;
  int   cnt = 0, n_ops = 0;
  logic [1:0] op_log [64];
  logic [3:0] st_log [64];
  logic       nk_log [64];
  logic [7:0] wd_log [64];

  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_nack_last(bus_nack_last),
    .bus_done(bus_done), .bus_ack(bus_ack), .bus_busy(bus_busy),
    .bus_rd_ok(bus_rd_ok), .bus_rdata(bus_rdata), .irq_status(irq_status)
  );

  // bit-engine model: answers each request after LAT cycles
  always @(posedge clk) begin
    if (rst) begin
      bus_done <= 0; cnt <= 0; bus_busy <= 0;
    end else if (bus_done) begin
      bus_done <= 0;
    end else if (bus_req) begin
      if (cnt == LAT - 1) begin
        cnt <= 0;
        bus_done <= 1;
        op_log[n_ops % 64] <= bus_op;
        st_log[n_ops % 64] <= reg_rdata[22:19];
        nk_log[n_ops % 64] <= bus_nack_last;
        wd_log[n_ops % 64] <= bus_wdata;
        n_ops <= n_ops + 1;
        case (bus_op)
          2'd0: begin bus_ack <= m_sack; bus_busy <= m_sack; end
          2'd1: bus_ack <= m_tack;
          2'd2: begin bus_rd_ok <= m_rok; bus_rdata <= m_rdata; end
          default: bus_busy <= 0;
        endcase
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    repeat (2) @(negedge clk);
    rd(2'd0, c);
    while (c[15:0] != 0) rd(2'd0, c);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state (R8)
    chk(bus_req == 0, "R9", "req after reset", bus_req, 0);
    rd(2'd0, rv); chk(rv == 0, "R8", "cmd reg reset", rv, 0);
    rd(2'd1, rv); chk(rv == 0, "R8", "buffer reset", rv, 0);
    rd(2'd2, rv); chk(rv == 0, "R8", "irq reset", rv, 0);
    wr(2'd1, 32'h0000_00C3);
    rd(2'd1, rv); chk(rv == 32'hC3, "R8", "buffer readback", rv, 32'hC3);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int base;
      v = VECS[i];
      wr(2'd1, {24'h0, v.bfr});
      m_sack = v.sack; m_tack = v.tack; m_rok = v.rok; m_rdata = v.rdat;
      base = n_ops;
      wr(2'd0, {27'h0, v.cmd});
      wait_idle();
      rd(2'd2, rv);
      chk(rv[3:0] == v.irq, "R1 R4 R5 R7", $sformatf("v%0d irq", i), rv, v.irq);
      rd(2'd0, rv);
      chk(rv[22:19] == v.st, "R3 R7", $sformatf("v%0d state", i), rv[22:19], v.st);
      chk(rv[15:0] == 0, "R2", $sformatf("v%0d cmd bits clear", i), rv[15:0], 0);
      chk(n_ops - base == int'(v.n), "R4 R7", $sformatf("v%0d op count", i), n_ops - base, v.n);
      for (int k = 0; k < int'(v.n); k++) begin
        chk(op_log[(base+k)%64] == v.seq[2*k +: 2], "R2 R9",
            $sformatf("v%0d op %0d", i, k), op_log[(base+k)%64], v.seq[2*k +: 2]);
        if (op_log[(base+k)%64] == 2'd2)
          chk(nk_log[(base+k)%64] == v.nack, "R6", $sformatf("v%0d nack", i),
              nk_log[(base+k)%64], v.nack);
      end
      if (v.n != 0) begin
        chk(st_log[base%64] == v.st0, "R3", $sformatf("v%0d first-phase state", i),
            st_log[base%64], v.st0);
        if (op_log[base%64] == 2'd0)
          chk(wd_log[base%64] == v.bfr, "R4", $sformatf("v%0d address byte", i),
              wd_log[base%64], v.bfr);
      end
      if (v.chk_rx) begin
        rd(2'd1, rv);
        chk(rv[15:8] == v.rx, "R6", $sformatf("v%0d rx byte", i), rv[15:8], v.rx);
      end
    end

    // R1: command written during a run is ignored (state idle -> start+tx, then stray stop)
    m_sack = 1; m_tack = 1;
    wr(2'd1, 32'h0000_00A0);
    wr(2'd0, 32'h0000_0003);
    wr(2'd0, 32'h0000_0010);
    wait_idle();
    rd(2'd0, rv);
    chk(rv[22:19] == 4'h8, "R1", "ignored stop leaves ACTIVE", rv[22:19], 4'h8);
    rd(2'd2, rv);
    chk(rv[3:0] == 4'h1, "R1", "ignored write keeps ACK only", rv[3:0], 4'h1);
    // close transfer cleanly (R7)
    wr(2'd0, 32'h0000_0010);
    wait_idle();
    rd(2'd2, rv);
    chk(rv[3:0] == 4'h4, "R7", "final normal stop", rv[3:0], 4'h4);
    rd(2'd0, rv);
    chk(rv[22:19] == 4'h0, "R7", "idle after stop", rv[22:19], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule